// File: doc/BRIEF.md
# Frame-Aligned Word Counter Preset Sequencer

This block keeps a three-digit decimal word counter aligned to the frame structure of a serial data stream. The counter advances by one on every word strobe. A small sequencer watches three inputs: an end-of-scan strobe, a flag that marks word 24, and a flag that marks the minor-frame terminal count. When all three are high in the same cycle, the sequencer arms.

Once armed, the sequencer waits for the next end-of-scan strobe. That strobe starts a preset phase, in which the counter is forced to 000 and word strobes are discarded. The end-of-scan strobe after that ends the preset phase, and counting resumes. All inputs are single-cycle control pulses or levels sampled on the rising clock edge. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. A word strobe is either counted or discarded in the cycle it is presented.

Top module: `frame_word_preset_seq`

## Requirements
- R1: After a synchronous reset, `count` is 000, `preset_active` is 0 and `count_en` is 1.
- R2: While the block is not presetting, each cycle with `word_stb` high adds one to the counter. `count[3:0]` is the units digit, `count[7:4]` the tens digit and `count[11:8]` the hundreds digit, each in BCD.
- R3: A digit that passes 9 returns to 0 and carries one into the next digit. From 999 the counter wraps to 000.
- R4: The sequencer arms only in a cycle where `eos_stb`, `w24_flag` and `tc_flag` are all high. Any subset of these inputs leaves the sequencer idle, so a later lone `eos_stb` starts no preset.
- R5: When the sequencer is armed, the next cycle with `eos_stb` high has this effect at the following clock edge: `preset_active` goes to 1, `count_en` goes to 0 and `count` becomes 000. A `word_stb` in that same cycle is discarded. Cycles without `eos_stb` leave the sequencer armed, and the counter keeps counting.
- R6: While `preset_active` is 1, `count` stays at 000 and `word_stb` has no effect.
- R7: The next `eos_stb` during the preset phase ends it at the following clock edge: `preset_active` goes to 0 and `count_en` goes to 1. A `word_stb` in that same cycle is discarded, and the first strobe after it gives 001.
- R8: An arm coincidence that arrives while the sequencer is armed or presetting is ignored. Such a coincidence also acts as the `eos_stb` of the phase in progress.
- R9: A reset in the middle of a sequence returns the sequencer to idle and the counter to 000 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| word_stb | input | 1 | One word has passed; count it |
| eos_stb | input | 1 | End-of-scan strobe |
| w24_flag | input | 1 | Current word is word 24 |
| tc_flag | input | 1 | Minor-frame terminal count reached |
| count | output | 12 | Word count, three BCD digits, units digit lowest |
| preset_active | output | 1 | Counter is held at zero |
| count_en | output | 1 | Counter accepts word strobes |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. This holds for arming, entering and leaving the preset phase, and for each counter step or carry, because every output comes straight from a register. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It then compares all three outputs with the model on the next falling edge. Each stimulus is therefore judged exactly one edge after it was sampled, and never in the cycle that produced it.

// File: rtl/wcps_pkg.sv
package wcps_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_PRESET = 2'd2
  } seq_state_e;

endpackage

// File: rtl/wcps_bcd_digit.sv
module wcps_bcd_digit #(
  parameter int RADIX = 10,
  localparam int DW = $clog2(RADIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [DW-1:0] q,
  output logic          carry
);

  localparam logic [DW-1:0] MAXV  = DW'(RADIX - 1);
  localparam logic [DW-1:0] ONE_V = DW'(1);

  logic at_max;
  assign at_max = (q == MAXV);
  assign carry  = inc & at_max;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc) begin
      q <= at_max ? '0 : q + ONE_V;
    end
  end

  assert_digit_step_R2: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && q != MAXV) |=> (q == $past(q) + ONE_V));

  assert_digit_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && q == MAXV) |=> (q == '0));

  assert_digit_range_R3: assert property (@(posedge clk) disable iff (rst)
    (q <= MAXV));

  assert_digit_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

endmodule

// File: rtl/wcps_word_counter.sv
module wcps_word_counter #(
  parameter int NUM_DIGITS = 3,
  parameter int RADIX = 10,
  localparam int DW = $clog2(RADIX),
  localparam int CW = NUM_DIGITS * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          word_stb,
  output logic [CW-1:0] count
);

  logic [NUM_DIGITS:0] chain;
  assign chain[0] = word_stb & ~clr;

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
    wcps_bcd_digit #(.RADIX(RADIX)) u_digit (
      .clk   (clk),
      .rst   (rst),
      .clr   (clr),
      .inc   (chain[gi]),
      .q     (count[gi*DW +: DW]),
      .carry (chain[gi+1])
    );
  end

  assert_full_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    chain[NUM_DIGITS] |=> (count == '0));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!word_stb && !clr) |=> $stable(count));

endmodule

// File: rtl/wcps_ctrl.sv
module wcps_ctrl
  import wcps_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic eos_stb,
  input  logic w24_flag,
  input  logic tc_flag,
  output logic clear,
  output logic preset_active,
  output logic count_en
);

  seq_state_e state_q, state_d;
  logic       arm_hit;

  assign arm_hit = eos_stb & w24_flag & tc_flag;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:   if (arm_hit) state_d = SEQ_ARMED;
      SEQ_ARMED:  if (eos_stb) state_d = SEQ_PRESET;
      SEQ_PRESET: if (eos_stb) state_d = SEQ_IDLE;
      default:    state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= state_d;
  end

  assign preset_active = (state_q == SEQ_PRESET);
  assign count_en      = ~preset_active;
  assign clear         = preset_active | ((state_q == SEQ_ARMED) & eos_stb);

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (state_q == SEQ_IDLE));

  assert_arm_needs_all_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_IDLE && !arm_hit) |=> (state_q == SEQ_IDLE));

  assert_preset_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_ARMED && eos_stb) |=> (state_q == SEQ_PRESET));

  assert_armed_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_ARMED && !eos_stb) |=> (state_q == SEQ_ARMED));

  assert_preset_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_PRESET && eos_stb) |=> (state_q == SEQ_IDLE));

  assert_no_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_PRESET && !eos_stb) |=> (state_q == SEQ_PRESET));

endmodule

// File: rtl/frame_word_preset_seq.sv
module frame_word_preset_seq #(
  parameter int NUM_DIGITS = 3,
  parameter int RADIX = 10,
  localparam int DW = $clog2(RADIX),
  localparam int CW = NUM_DIGITS * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_stb,
  input  logic          eos_stb,
  input  logic          w24_flag,
  input  logic          tc_flag,
  output logic [CW-1:0] count,
  output logic          preset_active,
  output logic          count_en
);

  logic clear;

  wcps_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .eos_stb       (eos_stb),
    .w24_flag      (w24_flag),
    .tc_flag       (tc_flag),
    .clear         (clear),
    .preset_active (preset_active),
    .count_en      (count_en)
  );

  wcps_word_counter #(.NUM_DIGITS(NUM_DIGITS), .RADIX(RADIX)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (clear),
    .word_stb (word_stb),
    .count    (count)
  );

  assert_zero_in_preset_R6: assert property (@(posedge clk) disable iff (rst)
    preset_active |-> (count == '0));

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && count_en));

endmodule

// File: tb/frame_word_preset_seq_tb.sv
module frame_word_preset_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_stb = 1'b0;
  logic        eos_stb = 1'b0;
  logic        w24_flag = 1'b0;
  logic        tc_flag = 1'b0;
  logic [11:0] count;
  logic        preset_active;
  logic        count_en;

  int    errors = 0;
  int    checks = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model
  int m_count = 0;
  bit m_armed = 0;
  bit m_preset = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_word_preset_seq dut_i (
    .clk           (clk),
    .rst           (rst),
    .word_stb      (word_stb),
    .eos_stb       (eos_stb),
    .w24_flag      (w24_flag),
    .tc_flag       (tc_flag),
    .count         (count),
    .preset_active (preset_active),
    .count_en      (count_en)
  );

  function automatic logic [11:0] to_bcd(int v);
    return {4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  always @(posedge clk) begin
    bit hit, wipe;
    hit  = eos_stb && w24_flag && tc_flag;
    wipe = (m_armed && eos_stb) || m_preset;
    started = 1;
    if (rst) begin
      m_armed = 0; m_preset = 0; m_count = 0;
    end else begin
      if (wipe) m_count = 0;
      else if (word_stb) m_count = (m_count + 1) % 1000;
      if (!m_armed && !m_preset) begin
        if (hit) m_armed = 1;
      end else if (m_armed) begin
        if (eos_stb) begin m_armed = 0; m_preset = 1; end
      end else if (eos_stb) begin
        m_preset = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      logic [11:0] exp_cnt;
      exp_cnt = to_bcd(m_count);
      checks++;
      if (count !== exp_cnt || preset_active !== m_preset || count_en !== !m_preset) begin
        errors++;
        $display("FAIL %s: count=%h preset=%b en=%b expected count=%h preset=%b en=%b",
                 cur_req, count, preset_active, count_en, exp_cnt, m_preset, !m_preset);
      end
    end
  end

  task automatic drive(bit s, bit e, bit w, bit t);
    @(negedge clk);
    #1;
    word_stb = s; eos_stb = e; w24_flag = w; tc_flag = t;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0);
  endtask

  task automatic arm();
    drive(0, 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    cur_req = "R1";
    idle(2);

    cur_req = "R2";
    for (int i = 0; i < 40; i++) drive(1'($urandom_range(0, 1)), 0, 0, 0);

    cur_req = "R3";
    for (int i = 0; i < 1010; i++) drive(1, 0, 0, 0);
    idle(1);

    cur_req = "R4";
    for (int m = 0; m < 7; m++) begin
      drive(1, m[0], m[1], m[2]);
      drive(1, 1, 0, 0);
      idle(1);
    end

    cur_req = "R5";
    arm();
    for (int i = 0; i < 5; i++) drive(1, 0, 0, 0);
    drive(1, 1, 0, 0);

    cur_req = "R6";
    for (int i = 0; i < 8; i++) drive(1, 0, 1, 1);

    cur_req = "R7";
    drive(1, 1, 0, 0);
    drive(1, 0, 0, 0);
    drive(1, 0, 0, 0);
    idle(1);

    cur_req = "R8";
    arm();
    arm();
    drive(1, 0, 0, 0);
    arm();
    drive(1, 0, 0, 0);
    idle(2);

    cur_req = "R9";
    arm();
    drive(1, 0, 0, 0);
    #1 rst = 1;
    drive(1, 1, 0, 0);
    #1 rst = 0;
    drive(1, 1, 0, 0);
    drive(1, 0, 0, 0);
    arm();
    drive(0, 1, 0, 0);
    #1 rst = 1;
    idle(1);
    #1 rst = 0;
    idle(2);

    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      bit e, w, t;
      e = ($urandom_range(0, 9) == 0);
      w = ($urandom_range(0, 2) != 0);
      t = ($urandom_range(0, 2) != 0);
      drive(1'($urandom_range(0, 3) != 0), e, w, t);
    end
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule